// File: doc/BRIEF.md
# One-bit IF quadrature downconverter with CIC decimation

This block takes an intermediate-frequency signal that has already been reduced to one bit, for example by a differential comparator, with one sample on every edge of the fast sample clock. A bit value of 1 counts as +1 and a value of 0 counts as −1. A numerically controlled oscillator produces cosine and sine of a programmable carrier. Because each sample is only a sign, mixing comes down to keeping or negating the oscillator values. This forms the in-phase (I) and quadrature (Q) products.

Each product is filtered and decimated by a three-stage cascaded integrator-comb filter with a small ratio (default 5). The filtered word is then rounded and clipped to a 16-bit signed value. A one-cycle strobe marks each decimated I/Q pair. The nominal use is a 240 MHz sample clock with a 10 MHz carrier, which gives a phase step of about 2^32/24.

Top module: `ifq_cic_ddc`

## Requirements
- R1: A 1 on `if_bit` is mixed as +1 and a 0 as −1. With `phase_inc` = 0 and `if_bit` held at 1, every I output from the third onward is +7996 (default parameters). With `if_bit` held at 0 it is −7996.
- R2: The phase register is 32 bits wide. It starts at 0 after reset and adds `phase_inc` modulo 2^32 once per sample, so sample n uses phase n·inc. The top 6 phase bits give an index p. The I product of a sample is sign·round(2047·cos(2πp/64)) and the Q product is sign·round(2047·sin(2πp/64)), with halves rounded away from zero.
- R3: Each path sums its products three times over, starting from zero. Decimated output k takes the triple sum at sample kR+R−1 and applies three successive first differences across decimated samples, with zero initial history. R is the decimation ratio, default 5.
- R4: `out_valid` is high for exactly the one cycle after the clock edge that takes sample kR+R−1, and is low otherwise. There is one pulse per R samples.
- R5: The filter word is W = 12 + 3·ceil(log2 R) bits (21 by default). The output is floor((c + 2^(W−17)) / 2^(W−16)), clipped to the range −32767 to +32767.
- R6: While `rst_n` is low at a clock edge, the block clears the phase, the integrators, the comb history and the decimation counter. `out_valid` is then 0 and both outputs are 0.
- R7: `out_i` and `out_q` keep their values in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one IF bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_inc | input | 32 | Oscillator phase step per sample |
| if_bit | input | 1 | One-bit IF sample (1 = +1, 0 = −1) |
| out_i | output | 16 | Decimated in-phase sample, signed |
| out_q | output | 16 | Decimated quadrature sample, signed |
| out_valid | output | 1 | One-cycle strobe for a new I/Q pair |

## Verification
The checker takes for granted that `rst_n` is low from time zero until after a few edges. It also assumes the ratio is at least 3, so strobes are always separated by idle cycles, and that `if_bit` and `phase_inc` change only away from the rising edge. The bench drives every input on the falling edge and holds reset from the start. Between scenarios it re-enters reset only through a task that keeps reset low for three edges. Its reference model recomputes the oscillator, the sums and the differences with wide integers from the stated formulas. The patterns are constant signs, a pseudo-random sequence with a wrapping phase step, a half-rate carrier, and a comparator-sliced tone near 10 MHz.

// File: rtl/ddc_pkg.sv
// Package for the one-bit downconverter.
// Holds the amplitude and output widths and a constant function that builds
// sine table entries at elaboration time (no stored table text).
package ddc_pkg;
    localparam int AMP_W = 12;
    localparam int OUT_W = 16;

    // Rounded sine code for entry i of an n-entry full-wave table.
    // Uses a Taylor series after folding the angle into [-pi, pi].
    function automatic int sine_code(input int i, input int n, input int amp_w);
        real x;
        real term;
        real acc;
        real pk;
        x = 2.0 * 3.14159265358979 * real'(i) / real'(n);
        if (x > 3.14159265358979) x = x - 2.0 * 3.14159265358979;
        acc  = x;
        term = x;
        for (int k = 1; k < 10; k++) begin
            term = -term * x * x / (real'(2 * k) * real'(2 * k + 1));
            acc  = acc + term;
        end
        pk = acc * real'((1 << (amp_w - 1)) - 1);
        if (pk >= 0.0) return $rtoi(pk + 0.5);
        else return -$rtoi(0.5 - pk);
    endfunction
endpackage

// File: rtl/ddc_nco.sv
// Phase accumulator with a full-wave sine table.
// Assumes TAB_BITS >= 2 so a quarter-turn offset exists. The outputs are
// combinational from the phase register, so they belong to the current sample.
module ddc_nco #(
    parameter int PH_W     = 32,
    parameter int TAB_BITS = 6,
    parameter int AMP_W    = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PH_W-1:0]         phase_inc,
    output logic signed [AMP_W-1:0] cos_o,
    output logic signed [AMP_W-1:0] sin_o
);
    localparam int NTAB = 1 << TAB_BITS;
    localparam int QTR  = NTAB / 4;

    logic [PH_W-1:0]         phase;
    logic [TAB_BITS-1:0]     idx_s;
    logic [TAB_BITS-1:0]     idx_c;
    logic signed [AMP_W-1:0] lut [NTAB];

    // Advance the phase by one step per sample; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + phase_inc;
    end

    // Build the table entries from the constant function.
    for (genvar g = 0; g < NTAB; g++) begin : g_tab
        localparam logic signed [AMP_W-1:0] V = AMP_W'(ddc_pkg::sine_code(g, NTAB, AMP_W));
        assign lut[g] = V;
    end

    // Address sine with the top phase bits; cosine sits a quarter turn ahead.
    always_comb begin
        idx_s = phase[PH_W-1 -: TAB_BITS];
        idx_c = idx_s + TAB_BITS'(QTR);
        sin_o = lut[idx_s];
        cos_o = lut[idx_c];
    end
endmodule

// File: rtl/ddc_sign_mix.sv
// Sign mixer: multiplies both oscillator outputs by a one-bit sample (+1/-1).
// Assumes the table never holds the most negative code, so negation is exact.
module ddc_sign_mix #(
    parameter int AMP_W = 12
) (
    input  logic                    bit_in,
    input  logic signed [AMP_W-1:0] cos_in,
    input  logic signed [AMP_W-1:0] sin_in,
    output logic signed [AMP_W-1:0] i_o,
    output logic signed [AMP_W-1:0] q_o
);
    // Keep or negate each product according to the sample sign.
    always_comb begin
        i_o = bit_in ? cos_in : -cos_in;
        q_o = bit_in ? sin_in : -sin_in;
    end
endmodule

// File: rtl/ddc_cic3.sv
// Three-stage CIC decimator with round-half-up and symmetric clipping.
// Assumes DEC >= 3 and a filter width above OUT_W. The integrators wrap in
// two's complement; combs and the output register update only on dump.
module ddc_cic3 #(
    parameter int IN_W  = 12,
    parameter int DEC   = 5,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dump,
    input  logic signed [IN_W-1:0]  x_in,
    output logic signed [OUT_W-1:0] y_out
);
    localparam int NST = 3;
    localparam int W   = IN_W + NST * $clog2(DEC);
    localparam int SH  = W - OUT_W;
    localparam int FS  = (1 << (OUT_W - 1)) - 1;
    localparam logic signed [W:0]    HALF = (W+1)'(1) << (SH - 1);
    localparam logic signed [W-SH:0] POS  = (W-SH+1)'(FS);
    localparam logic signed [W-SH:0] NEG  = -POS;

    typedef logic signed [W-1:0] acc_t;

    acc_t integ    [NST];
    acc_t integ_nx [NST];
    acc_t dly      [NST];
    acc_t diff     [NST+1];
    logic signed [W:0]       rsum;
    logic signed [W-SH:0]    shr;
    logic signed [OUT_W-1:0] sat;

    // Integrator chain, comb chain and rounding for the current sample.
    always_comb begin
        integ_nx[0] = integ[0] + {{(W-IN_W){x_in[IN_W-1]}}, x_in};
        for (int s = 1; s < NST; s++) integ_nx[s] = integ[s] + integ_nx[s-1];
        diff[0] = integ_nx[NST-1];
        for (int s = 0; s < NST; s++) diff[s+1] = diff[s] - dly[s];
        rsum = {diff[NST][W-1], diff[NST]} + HALF;
        shr  = rsum[W:SH];
        if (shr > POS)      sat = POS[OUT_W-1:0];
        else if (shr < NEG) sat = NEG[OUT_W-1:0];
        else                sat = shr[OUT_W-1:0];
    end

    // Register integrators every sample and combs/output on the decimation strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NST; s++) begin
                integ[s] <= '0;
                dly[s]   <= '0;
            end
            y_out <= '0;
        end else begin
            for (int s = 0; s < NST; s++) integ[s] <= integ_nx[s];
            if (dump) begin
                for (int s = 0; s < NST; s++) dly[s] <= diff[s];
                y_out <= sat;
            end
        end
    end
endmodule

// File: rtl/ifq_cic_ddc.sv
// Top level: oscillator, sign mixer, decimation counter and two CIC paths.
// Assumes one IF bit on every clock edge and DEC >= 3.
module ifq_cic_ddc #(
    parameter int PH_W     = 32,
    parameter int TAB_BITS = 6,
    parameter int DEC      = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [PH_W-1:0]                  phase_inc,
    input  logic                             if_bit,
    output logic signed [ddc_pkg::OUT_W-1:0] out_i,
    output logic signed [ddc_pkg::OUT_W-1:0] out_q,
    output logic                             out_valid
);
    localparam int AMP_W = ddc_pkg::AMP_W;
    localparam int OUT_W = ddc_pkg::OUT_W;
    localparam int CW    = $clog2(DEC);

    logic signed [AMP_W-1:0] nco_cos;
    logic signed [AMP_W-1:0] nco_sin;
    logic signed [AMP_W-1:0] mix_i;
    logic signed [AMP_W-1:0] mix_q;
    logic [CW-1:0]           dec_cnt;
    logic                    dump;

    assign dump = (dec_cnt == CW'(DEC - 1));

    // Count samples within a decimation window and register the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_cnt   <= '0;
            out_valid <= 1'b0;
        end else begin
            dec_cnt   <= dump ? '0 : dec_cnt + 1'b1;
            out_valid <= dump;
        end
    end

    ddc_nco #(.PH_W(PH_W), .TAB_BITS(TAB_BITS), .AMP_W(AMP_W)) nco_i (
        .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc),
        .cos_o(nco_cos), .sin_o(nco_sin)
    );

    ddc_sign_mix #(.AMP_W(AMP_W)) mix_u (
        .bit_in(if_bit), .cos_in(nco_cos), .sin_in(nco_sin),
        .i_o(mix_i), .q_o(mix_q)
    );

    ddc_cic3 #(.IN_W(AMP_W), .DEC(DEC), .OUT_W(OUT_W)) cic_i_u (
        .clk(clk), .rst_n(rst_n), .dump(dump), .x_in(mix_i), .y_out(out_i)
    );

    ddc_cic3 #(.IN_W(AMP_W), .DEC(DEC), .OUT_W(OUT_W)) cic_q_u (
        .clk(clk), .rst_n(rst_n), .dump(dump), .x_in(mix_q), .y_out(out_q)
    );
endmodule

// File: rtl/ddc_chk.sv
// Port-level checker for ifq_cic_ddc, attached with bind.
// Assumes reset is asserted from time zero. Measures the strobe spacing with
// its own counter so no deep history is needed.
module ddc_chk #(
    parameter int DEC = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic signed [15:0] out_i,
    input logic signed [15:0] out_q,
    input logic               out_valid
);
    localparam int GW = $clog2(DEC) + 2;
    logic [GW-1:0] gap;

    // Cycles since reset or since the last strobe, saturating at DEC.
    always_ff @(posedge clk) begin
        if (!rst_n)                 gap <= '0;
        else if (out_valid)         gap <= GW'(1);
        else if (gap < GW'(DEC))    gap <= gap + 1'b1;
    end

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R4
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> gap == GW'(DEC));
    // R4
    strobe_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap >= GW'(DEC)) |-> out_valid);
    // R5
    clip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_i != 16'sh8000 && out_q != 16'sh8000);
    // R6
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_i == 16'sd0 && out_q == 16'sd0));
    // R7
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind ifq_cic_ddc ddc_chk #(.DEC(DEC)) chk_u (
    .clk(clk), .rst_n(rst_n), .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
);

// File: tb/ifq_cic_ddc_tb_top.sv
// Directed bench: each task resets, drives one pattern and compares every
// cycle against a wide-integer model written from the requirements.
module ifq_cic_ddc_tb_top;
    localparam int CLK_PERIOD = 4;
    localparam int DEC        = 5;
    localparam int SHIFT      = 5;
    localparam int FULL       = 32767;
    localparam real PI        = 3.14159265358979;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [31:0]        phase_inc = '0;
    logic               if_bit = 1'b0;
    logic signed [15:0] out_i;
    logic signed [15:0] out_q;
    logic               out_valid;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifq_cic_ddc dut_i (
        .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .if_bit(if_bit),
        .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
    );

    function automatic int table_amp(longint unsigned ph, bit use_cos);
        int  idx;
        real v;
        idx = int'(ph >> 26);
        v = 2047.0 * (use_cos ? $cos(2.0 * PI * idx / 64.0) : $sin(2.0 * PI * idx / 64.0));
        if (v >= 0.0) return $rtoi(v + 0.5);
        else return -$rtoi(0.5 - v);
    endfunction

    function automatic int scale_out(longint c);
        longint t;
        t = (c + (64'sd1 <<< (SHIFT - 1))) >>> SHIFT;
        if (t > FULL) t = FULL;
        if (t < -FULL) t = -FULL;
        return int'(t);
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // R6: hold reset for three edges after activity, then check cleared outputs.
    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R6", "valid in reset", out_valid, 0);
        check(out_i == 16'sd0, "R6", "I in reset", out_i, 0);
        check(out_q == 16'sd0, "R6", "Q in reset", out_q, 0);
    endtask

    // Run one pattern: 0 const 1, 1 const 0, 2 lfsr, 3 sliced tone, 4 alternating.
    task automatic run_pattern(input logic [31:0] inc, input int mode, input int nsamp,
                               input string tag, output int last_i, output int last_q);
        longint unsigned ph;
        longint integ [2][3];
        longint hist  [2][3];
        longint x [2];
        longint c;
        longint t;
        int     exp_i;
        int     exp_q;
        bit     b;
        bit     due;
        logic [15:0] lfsr;
        ph = 0;
        exp_i = 0;
        exp_q = 0;
        lfsr = 16'hACE1;
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 3; s++) begin
                integ[p][s] = 0;
                hist[p][s] = 0;
            end
        end
        apply_reset();
        phase_inc = inc;
        rst_n = 1'b1;
        for (int n = 0; n < nsamp; n++) begin
            case (mode)
                0: b = 1'b1;
                1: b = 1'b0;
                2: begin
                    b = lfsr[0];
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                end
                3: b = ($cos(2.0 * PI * 0.041875 * n + 0.3) > 0.0);
                default: b = n[0] ? 1'b0 : 1'b1;
            endcase
            if_bit = b;
            x[0] = (b ? 1 : -1) * table_amp(ph, 1'b1);
            x[1] = (b ? 1 : -1) * table_amp(ph, 1'b0);
            ph = (ph + inc) % 64'h1_0000_0000;
            for (int p = 0; p < 2; p++) begin
                integ[p][0] += x[p];
                integ[p][1] += integ[p][0];
                integ[p][2] += integ[p][1];
            end
            due = ((n % DEC) == DEC - 1);
            if (due) begin
                for (int p = 0; p < 2; p++) begin
                    c = integ[p][2];
                    for (int s = 0; s < 3; s++) begin
                        t = c - hist[p][s];
                        hist[p][s] = c;
                        c = t;
                    end
                    if (p == 0) exp_i = scale_out(c);
                    else        exp_q = scale_out(c);
                end
            end
            @(negedge clk);
            check(out_valid == due, "R4", {tag, " strobe"}, out_valid, due);
            if (due) begin
                check(out_i == exp_i, "R3 R5", {tag, " I"}, out_i, exp_i);
                check(out_q == exp_q, "R3 R5", {tag, " Q"}, out_q, exp_q);
            end else begin
                check(out_i == exp_i, "R7", {tag, " I hold"}, out_i, exp_i);
                check(out_q == exp_q, "R7", {tag, " Q hold"}, out_q, exp_q);
            end
        end
        last_i = out_i;
        last_q = out_q;
    endtask

    task automatic test_dc_plus();
        int li, lq;
        run_pattern(32'd0, 0, 40, "dc plus", li, lq);
        check(li == 7996, "R1", "dc plus steady I", li, 7996);
        check(lq == 0, "R2", "dc plus steady Q", lq, 0);
    endtask

    task automatic test_dc_minus();
        int li, lq;
        run_pattern(32'd0, 1, 40, "dc minus", li, lq);
        check(li == -7996, "R1", "dc minus steady I", li, -7996);
        check(lq == 0, "R2", "dc minus steady Q", lq, 0);
    endtask

    task automatic test_half_rate();
        int li, lq;
        run_pattern(32'h8000_0000, 4, 60, "half rate", li, lq);
        check(li == 7996, "R2", "half-rate carrier I", li, 7996);
        check(lq == 0, "R2", "half-rate carrier Q", lq, 0);
    endtask

    task automatic test_lfsr_wrap();
        int li, lq;
        run_pattern(32'hF123_4567, 2, 500, "lfsr wrap", li, lq);
    endtask

    task automatic test_tone();
        int li, lq;
        run_pattern(32'd178956971, 3, 3000, "tone 10MHz", li, lq);
    endtask

    initial begin
        test_dc_plus();
        test_dc_minus();
        test_half_rate();
        test_lfsr_wrap();
        test_tone();
        apply_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule